// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the digital sequencer for an N-bit successive-approximation converter. A start strobe arms one conversion. The block then opens a one-cycle sampling window and walks a binary search from the most significant bit down to the least significant bit, one comparator decision per clock. The analog sample-and-hold, the capacitive DAC and the comparator sit outside the block. The block drives the DAC with a trial word. It reads back a single comparator bit each step.

Each position of the code register is a cell built from one flip-flop. A four-way select in front of that flip-flop picks one of four values: keep the value, accept the trial token passed down from the position above, load the comparator decision, or clear. Separate shift and result registers are therefore not needed. The same word drives the DAC during the search and holds the final code once the done strobe fires.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `dac_word_o` = 0, `result_o` = 0, `sample_o` = 0, `busy_o` = 0 and `done_o` = 0.
- R2: A `start_i` seen at an edge while `busy_o` is low gives a single cycle with `sample_o` = 1 and `busy_o` = 1. In that cycle `dac_word_o` has only bit W-1 set.
- R3: Exactly W comparison steps follow the sampling cycle. In step k (k = 0 is first), bits W-1 down to W-k hold the decisions already made, bit W-1-k is 1 as the trial bit, and all lower bits are 0.
- R4: `cmp_i` = 1 means the input is at or above the DAC level, and the trial bit stays 1. `cmp_i` = 0 clears it. With an ideal comparator, the final code equals the largest code not above the input.
- R5: `done_o` is high for exactly one cycle, W+1 cycles after the cycle with `sample_o` high. In that cycle `busy_o` is already low and no trial bit remains beyond the decided code.
- R6: `result_o` (equal to the register word) does not change from the done cycle until the next accepted start.
- R7: A `start_i` raised while `busy_o` is high has no effect: the running conversion keeps its timing and result, and `sample_o` does not rise again.
- R8: A reset in the middle of a conversion returns the block to idle at once, clears the word, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a conversion (sampled while idle) |
| cmp_i | input | 1 | Comparator decision for the current trial word |
| dac_word_o | output | W | Trial word to the DAC |
| sample_o | output | 1 | High during the sampling cycle |
| busy_o | output | 1 | High from the sampling cycle through the last step |
| result_o | output | W | Code register contents; the final code from the done pulse on |
| done_o | output | 1 | One-cycle strobe marking a finished conversion |

## Verification
Counting from the edge that accepts a start, the sampling cycle is visible one edge later and step k is visible k+2 edges later. The done strobe and the final code appear W+2 edges after that accepting edge. The comparator model responds combinationally to the DAC word, so each step's decision is the value present just before the edge that closes the step. The bench drives and samples only on falling edges. It counts falling edges from the start request and compares each output in exactly the cycle its result is due, so an early or late bit, strobe or phase change gives a mismatch.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_HOLD  = 2'd0,
        SEL_SHIFT = 2'd1,
        SEL_CMP   = 2'd2,
        SEL_CLR   = 2'd3
    } cell_sel_e;

endpackage

// File: rtl/sar_bit_cell.sv
module sar_bit_cell
    import sar_ctrl_pkg::*;
(
    input  logic      clk,
    input  cell_sel_e sel_i,
    input  logic      token_i,
    input  logic      cmp_i,
    output logic      bit_o
);

    logic bit_d;
    logic bit_q;

    always_comb begin
        unique case (sel_i)
            SEL_HOLD:  bit_d = bit_q;
            SEL_SHIFT: bit_d = token_i;
            SEL_CMP:   bit_d = cmp_i;
            default:   bit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        bit_q <= bit_d;
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_ctrl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    output phase_e       phase_o,
    output logic         load_o,
    output logic [W-1:0] trial_oh_o,
    output logic         done_o
);

    localparam int STW  = (W > 1) ? $clog2(W) : 1;
    localparam int LAST = W - 1;

    typedef struct packed {
        phase_e         phase;
        logic [STW-1:0] step;
        logic           done;
    } seq_t;

    seq_t st_d;
    seq_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_SAMPLE;
                    st_d.step  = '0;
                end
            end
            PH_SAMPLE: begin
                st_d.phase = PH_CONV;
            end
            PH_CONV: begin
                if (int'(st_q.step) == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.step  = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (rst) begin
            st_d = '{phase: PH_IDLE, step: '0, done: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            trial_oh_o[i] = (st_q.phase == PH_CONV) && (i == (LAST - int'(st_q.step)));
        end
    end

    assign phase_o = st_q.phase;
    assign load_o  = (st_q.phase == PH_IDLE) && start_i && !rst;
    assign done_o  = st_q.done;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic [W-1:0] dac_word_o,
    output logic         sample_o,
    output logic         busy_o,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    phase_e       phase;
    logic         load;
    logic [W-1:0] trial_oh;
    logic [W-1:0] word;

    sar_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .phase_o    (phase),
        .load_o     (load),
        .trial_oh_o (trial_oh),
        .done_o     (done_o)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        cell_sel_e sel;
        logic      token;

        if (i == W - 1) begin : g_top
            assign token = load;
        end else begin : g_low
            assign token = trial_oh[i+1];
        end

        always_comb begin
            if (rst) begin
                sel = SEL_CLR;
            end else if (load) begin
                sel = (i == W - 1) ? SEL_SHIFT : SEL_CLR;
            end else if (trial_oh[i]) begin
                sel = SEL_CMP;
            end else if (token && (i != W - 1)) begin
                sel = SEL_SHIFT;
            end else begin
                sel = SEL_HOLD;
            end
        end

        sar_bit_cell u_cell (
            .clk     (clk),
            .sel_i   (sel),
            .token_i (token),
            .cmp_i   (cmp_i),
            .bit_o   (word[i])
        );
    end

    assign dac_word_o = word;
    assign result_o   = word;
    assign sample_o   = (phase == PH_SAMPLE);
    assign busy_o     = (phase != PH_IDLE);

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] result_o,
    input logic         sample_o,
    input logic         busy_o,
    input logic         done_o
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy_o && !done_o && !sample_o && result_o == '0));

    // R2
    sample_single_chk: assert property (@(posedge clk) disable iff (rst) sample_o |=> !sample_o);

    // R2
    sample_busy_chk: assert property (@(posedge clk) disable iff (rst) sample_o |-> busy_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst) (!busy_o && !start_i) |=> $stable(result_o));

    // R7
    sample_from_idle_chk: assert property (@(posedge clk) disable iff (rst) $rose(sample_o) |-> !$past(busy_o));

endmodule

bind sar_ctrl sar_ctrl_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .result_o (result_o),
    .sample_o (sample_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/sar_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ctrl_tb;

    localparam int W = 8;
    localparam int NV = 8;
    localparam logic [W-1:0] VIN_TAB [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hA5, 8'h5A, 8'hFE};

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic         cmp_i;
    logic [W-1:0] dac_word_o;
    logic         sample_o;
    logic         busy_o;
    logic [W-1:0] result_o;
    logic         done_o;
    logic [W-1:0] vin;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // ideal comparator: 1 when input is at or above the DAC level
    assign cmp_i = (vin >= dac_word_o);

    sar_ctrl #(.W(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmp_i      (cmp_i),
        .dac_word_o (dac_word_o),
        .sample_o   (sample_o),
        .busy_o     (busy_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] trial_word(input logic [W-1:0] v, input int k);
        int iv;
        iv = int'(v);
        return W'(((iv >> (W - k)) << (W - k)) | (1 << (W - 1 - k)));
    endfunction

    // one full conversion; optional second start at step stray_k (R7)
    task automatic run_conv(input logic [W-1:0] v, input int stray_k);
        vin     = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 sample", {31'b0, sample_o}, 1);
        check("R2 busy", {31'b0, busy_o}, 1);
        check("R2 word", dac_word_o, {1'b1, {(W-1){1'b0}}});
        for (int k = 0; k < W; k++) begin
            if (k == stray_k) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check("R3 trial", dac_word_o, trial_word(v, k));
            check("R3 busy", {31'b0, busy_o}, 1);
            if (k == stray_k + 1) check("R7 no resample", {31'b0, sample_o}, 0);
        end
        @(negedge clk);
        check("R5 done", {31'b0, done_o}, 1);
        check("R5 idle", {31'b0, busy_o}, 0);
        check("R4 result", result_o, v);
        @(negedge clk);
        check("R5 done width", {31'b0, done_o}, 0);
        check("R6 hold", result_o, v);
        @(negedge clk);
        check("R6 hold2", result_o, v);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst     = 1'b1;
        start_i = 1'b0;
        vin     = '0;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 word", dac_word_o, 0);
        check("R1 busy", {31'b0, busy_o}, 0);
        check("R1 done", {31'b0, done_o}, 0);
        check("R1 sample", {31'b0, sample_o}, 0);
        rst = 1'b0;
        @(negedge clk);

        // table walk: R3 R4 R5 R6
        for (int n = 0; n < NV; n++) begin
            run_conv(VIN_TAB[n], -1);
        end

        // R7: start during busy at steps 3 and 0
        run_conv(8'h3C, 3);
        run_conv(8'hC3, 0);

        // R8: reset mid-conversion
        vin     = 8'h96;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 idle", {31'b0, busy_o}, 0);
        check("R8 word", dac_word_o, 0);
        for (int c = 0; c < W + 3; c++) begin
            @(negedge clk);
            check("R8 no done", {31'b0, done_o}, 0);
        end
        // R6: word unchanged while idle with no start
        check("R6 idle word", result_o, 0);

        // recovers normally after abort
        run_conv(8'h69, -1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule